// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block keeps DRAMs with internal refresh address counters alive by issuing CAS-before-RAS refresh transactions on a schedule. An interval timer raises one refresh request every `interval + 1` clock cycles while refresh is enabled. Each request is served as a burst of `burst_len + 1` back-to-back refresh transactions. Every transaction passes through three phases, T1, T2 and T3, and each phase can be stretched by its own wait count. During each transaction both byte enables and all chip selects chosen by `cs_sel` are driven active together, so every DRAM bank refreshes at once.

Another master may take the bus through `bus_req`. A burst that has started always completes before the grant is given. While the bus is away, requests raised by the timer cannot run. They are counted in a saturating pending counter and replayed back to back once the bus returns.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, `ref_frame_n`, `ref_cas_n`, `ref_ras_n`, all `be_n` bits and all `cs_n` bits are 1, and `busy` and `bus_grant` are 0.
- R2: While `enable` is 1, refresh bursts begin every `interval + 1` clock cycles, provided nothing delays them. While `enable` is 0, the timer raises no new requests.
- R3: Each request produces exactly `burst_len + 1` refresh transactions.
- R4: The strobes follow CAS-before-RAS order. In T1, `ref_frame_n`=0, `ref_cas_n`=0 and `ref_ras_n`=1. In T2, all three are 0. In T3, `ref_frame_n`=0 and the other two are 1. In T3, `ref_frame_n`=0 while `ref_cas_n` and `ref_ras_n` are 1. A following transaction starts again at T1.
- R5: Phases T1, T2 and T3 last `wait_t1 + 1`, `wait_t2 + 1` and `wait_t3 + 1` cycles respectively.
- R6: Throughout every transaction, `be_n` is 2'b00 and `cs_n` equals `~cs_sel`. Outside transactions, both are all ones.
- R7: `busy` is 1 from the first T1 cycle of a burst until the last T3 cycle of that burst, without a gap, and 0 in the cycle that follows.
- R8: `bus_grant` rises one cycle after `bus_req` is seen while no burst is active. A `bus_req` that arrives during a burst is granted only in the second cycle after `busy` falls. `bus_grant` falls one cycle after `bus_req` falls. When the block is idle, a bus request takes priority over a pending refresh.
- R9: While `bus_grant` is 1, no refresh runs. Each timer request raised in that time is counted, and once the bus is returned one burst runs for each counted request.
- R10: The pending-request counter saturates at 2^MISS_W - 1, which is 7 by default, instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Refresh timer enable |
| interval | input | IVL_W | Request period minus one, in cycles |
| burst_len | input | BURST_W | Transactions per request minus one |
| wait_t1 | input | WAIT_W | Extra cycles in T1 |
| wait_t2 | input | WAIT_W | Extra cycles in T2 |
| wait_t3 | input | WAIT_W | Extra cycles in T3 |
| cs_sel | input | NCS | Chip selects to activate during refresh |
| bus_req | input | 1 | External master requests the bus |
| bus_grant | output | 1 | Bus handed to the external master |
| busy | output | 1 | Refresh burst in progress |
| ref_frame_n | output | 1 | Refresh cycle frame strobe, active low |
| ref_cas_n | output | 1 | Refresh column strobe, active low |
| ref_ras_n | output | 1 | Refresh row strobe, active low |
| be_n | output | 2 | Byte enables, active low |
| cs_n | output | NCS | Chip selects, active low |

## Verification
The hardest case to reach is the replay of missed refreshes, together with the saturation of the pending counter. It needs a known number of timer requests to fall inside a grant window, and no request may be left pending when that window opens. The stimulus waits for a burst to end and raises `bus_req` at once. It holds the request for an exact multiple of the timer period, so exactly that many requests land in the window. It then drops `bus_req` and `enable` together, so that no new requests are added, and counts the bursts that replay. A window holding ten periods drives the counter past its limit.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_T1    = 3'd1,
    ST_T2    = 3'd2,
    ST_T3    = 3'd3,
    ST_GRANT = 3'd4
  } dref_state_e;
endpackage

// File: rtl/dref_tick.sv
// Periodic request timer: one tick every (interval + 1) enabled cycles.
module dref_tick #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [IVL_W-1:0] interval,
  output logic             tick
);
  logic [IVL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = enable && (cnt_q == interval);
    if (!enable || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dref_miss_cnt.sv
// Saturating count of refresh requests not yet served.
module dref_miss_cnt #(
  parameter int MISS_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pend_nz
);
  localparam logic [MISS_W-1:0] MAX_V = '1;

  logic [MISS_W-1:0] pend_q, pend_d;
  logic              pend_en;

  always_comb begin
    pend_en = inc ^ dec;
    pend_d  = pend_q;
    if (inc && !dec && pend_q != MAX_V) pend_d = pend_q + 1'b1;
    else if (dec && !inc)               pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_nz = (pend_q != '0);
endmodule

// File: rtl/dref_seq.sv
// Burst and phase sequencer with bus hand-off between bursts.
module dref_seq
  import dref_pkg::*;
#(
  parameter int BURST_W = 4,
  parameter int WAIT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pend_nz,
  input  logic               bus_req,
  input  logic [BURST_W-1:0] burst_len,
  input  logic [WAIT_W-1:0]  wait_t1,
  input  logic [WAIT_W-1:0]  wait_t2,
  input  logic [WAIT_W-1:0]  wait_t3,
  output dref_state_e        state,
  output logic               take
);
  dref_state_e        st_q, st_d;
  logic [WAIT_W-1:0]  wcnt_q, wcnt_d, phase_wait;
  logic [BURST_W-1:0] tcnt_q, tcnt_d;
  logic               phase_done;

  always_comb begin
    unique case (st_q)
      ST_T1:   phase_wait = wait_t1;
      ST_T2:   phase_wait = wait_t2;
      ST_T3:   phase_wait = wait_t3;
      default: phase_wait = '0;
    endcase
    phase_done = (wcnt_q == phase_wait);
  end

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    tcnt_d = tcnt_q;
    take   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (bus_req) begin
          st_d = ST_GRANT;
        end else if (pend_nz) begin
          st_d   = ST_T1;
          take   = 1'b1;
          wcnt_d = '0;
          tcnt_d = burst_len;
        end
      end
      ST_T1, ST_T2, ST_T3: begin
        if (!phase_done) begin
          wcnt_d = wcnt_q + 1'b1;
        end else begin
          wcnt_d = '0;
          if (st_q == ST_T1)      st_d = ST_T2;
          else if (st_q == ST_T2) st_d = ST_T3;
          else if (tcnt_q != '0) begin
            st_d   = ST_T1;
            tcnt_d = tcnt_q - 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_GRANT: begin
        if (!bus_req) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      tcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dref_pkg::*;
#(
  parameter int IVL_W   = 16,
  parameter int BURST_W = 4,
  parameter int WAIT_W  = 3,
  parameter int MISS_W  = 3,
  parameter int NCS     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [IVL_W-1:0]   interval,
  input  logic [BURST_W-1:0] burst_len,
  input  logic [WAIT_W-1:0]  wait_t1,
  input  logic [WAIT_W-1:0]  wait_t2,
  input  logic [WAIT_W-1:0]  wait_t3,
  input  logic [NCS-1:0]     cs_sel,
  input  logic               bus_req,
  output logic               bus_grant,
  output logic               busy,
  output logic               ref_frame_n,
  output logic               ref_cas_n,
  output logic               ref_ras_n,
  output logic [1:0]         be_n,
  output logic [NCS-1:0]     cs_n
);
  logic        tick, take, pend_nz, in_txn;
  dref_state_e state;

  dref_tick #(.IVL_W(IVL_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .interval (interval),
    .tick     (tick)
  );

  dref_miss_cnt #(.MISS_W(MISS_W)) u_miss (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (tick),
    .dec     (take),
    .pend_nz (pend_nz)
  );

  dref_seq #(.BURST_W(BURST_W), .WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_nz   (pend_nz),
    .bus_req   (bus_req),
    .burst_len (burst_len),
    .wait_t1   (wait_t1),
    .wait_t2   (wait_t2),
    .wait_t3   (wait_t3),
    .state     (state),
    .take      (take)
  );

  always_comb begin
    in_txn      = (state == ST_T1) || (state == ST_T2) || (state == ST_T3);
    busy        = in_txn;
    bus_grant   = (state == ST_GRANT);
    ref_frame_n = !in_txn;
    ref_cas_n   = !((state == ST_T1) || (state == ST_T2));
    ref_ras_n   = !(state == ST_T2);
    be_n        = in_txn ? 2'b00 : 2'b11;
    cs_n        = in_txn ? ~cs_sel : '1;
  end
endmodule

// File: rtl/dref_checker.sv
module dref_checker #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_grant,
  input logic           busy,
  input logic           ref_frame_n,
  input logic           ref_cas_n,
  input logic           ref_ras_n,
  input logic [1:0]     be_n,
  input logic [NCS-1:0] cs_n
);
  p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_ras_n) |-> $past(!ref_cas_n));

  p_first_is_t1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!ref_cas_n && ref_ras_n && !ref_frame_n));

  p_byte_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_frame_n |-> (be_n == 2'b00));

  p_idle_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_frame_n |-> (&cs_n && &be_n));

  p_grant_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> !busy);

  p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> $past(bus_req));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !bus_req) |=> !bus_grant);

  p_no_refresh_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (ref_frame_n && ref_cas_n && ref_ras_n));
endmodule

bind dram_refresh_ctrl dref_checker #(.NCS(NCS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_grant   (bus_grant),
  .busy        (busy),
  .ref_frame_n (ref_frame_n),
  .ref_cas_n   (ref_cas_n),
  .ref_ras_n   (ref_ras_n),
  .be_n        (be_n),
  .cs_n        (cs_n)
);

// File: tb/dram_refresh_ctrl_tb.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_tb;
  localparam int IVL_W = 16, BURST_W = 4, WAIT_W = 3, MISS_W = 3, NCS = 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               enable;
  logic [IVL_W-1:0]   interval;
  logic [BURST_W-1:0] burst_len;
  logic [WAIT_W-1:0]  wait_t1, wait_t2, wait_t3;
  logic [NCS-1:0]     cs_sel;
  logic               bus_req;
  logic               bus_grant, busy, ref_frame_n, ref_cas_n, ref_ras_n;
  logic [1:0]         be_n;
  logic [NCS-1:0]     cs_n;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_ctrl #(.IVL_W(IVL_W), .BURST_W(BURST_W), .WAIT_W(WAIT_W),
                      .MISS_W(MISS_W), .NCS(NCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .interval(interval),
    .burst_len(burst_len), .wait_t1(wait_t1), .wait_t2(wait_t2),
    .wait_t3(wait_t3), .cs_sel(cs_sel), .bus_req(bus_req),
    .bus_grant(bus_grant), .busy(busy), .ref_frame_n(ref_frame_n),
    .ref_cas_n(ref_cas_n), .ref_ras_n(ref_ras_n), .be_n(be_n), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_busy_rise(output bit found);
    found = 1'b0;
    for (int i = 0; i < 3000 && !found; i++) begin
      @(negedge clk);
      if (busy) found = 1'b1;
    end
  endtask

  task automatic wait_busy_low();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic quiesce();
    enable  = 1'b0;
    bus_req = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
    end
  endtask

  // R1: idle outputs after reset
  task automatic t_reset();
    @(negedge clk);
    chk(ref_frame_n && ref_cas_n && ref_ras_n, "R1", "strobes idle",
        {ref_frame_n, ref_cas_n, ref_ras_n}, 7);
    chk(be_n == 2'b11 && cs_n == '1, "R1", "be/cs idle", {be_n, cs_n}, 63);
    chk(!busy && !bus_grant, "R1", "busy/grant low", {busy, bus_grant}, 0);
  endtask

  // R3 R4 R5 R6 R7: full cycle-by-cycle shape of a two-transaction burst
  task automatic t_shape();
    bit found;
    int w[3];
    int exp_st;
    quiesce();
    interval = 16'd30; burst_len = 4'd1; cs_sel = 4'b1010;
    wait_t1 = 3'd2; wait_t2 = 3'd1; wait_t3 = 3'd3;
    w[0] = 2; w[1] = 1; w[2] = 3;
    enable = 1'b1;
    wait_busy_rise(found);
    chk(found, "R2", "burst started", found, 1);
    for (int t = 0; t < 2; t++) begin
      for (int p = 0; p < 3; p++) begin
        exp_st = (p == 0) ? 3'b001 : (p == 1) ? 3'b000 : 3'b011;
        for (int k = 0; k <= w[p]; k++) begin
          chk({ref_frame_n, ref_cas_n, ref_ras_n} == exp_st[2:0], "R4_R5",
              "strobe phase", {ref_frame_n, ref_cas_n, ref_ras_n}, exp_st);
          chk(be_n == 2'b00 && cs_n == 4'b0101, "R6", "be/cs active",
              {be_n, cs_n}, 5);
          chk(busy, "R7", "busy held", busy, 1);
          @(negedge clk);
        end
      end
    end
    chk(!busy && ref_frame_n && cs_n == '1 && be_n == 2'b11, "R7",
        "busy drops after last T3", busy, 0);
  endtask

  // R3: burst_len=3 gives four transactions
  task automatic t_burst_count();
    bit found;
    int falls = 0;
    logic prev_cas;
    quiesce();
    interval = 16'd40; burst_len = 4'd3; cs_sel = 4'b0001;
    wait_t1 = 3'd0; wait_t2 = 3'd0; wait_t3 = 3'd0;
    enable = 1'b1;
    wait_busy_rise(found);
    prev_cas = 1'b1;
    while (busy) begin
      if (prev_cas && !ref_cas_n) falls++;
      prev_cas = ref_cas_n;
      @(negedge clk);
    end
    chk(falls == 4, "R3", "transactions per burst", falls, 4);
  endtask

  // R2: period between burst starts; enable low stops requests
  task automatic t_interval();
    bit found;
    int t0, t1, t2;
    int seen = 0;
    quiesce();
    interval = 16'd20; burst_len = 4'd0;
    wait_t1 = 3'd0; wait_t2 = 3'd0; wait_t3 = 3'd0;
    enable = 1'b1;
    wait_busy_rise(found); t0 = cyc; wait_busy_low();
    wait_busy_rise(found); t1 = cyc; wait_busy_low();
    wait_busy_rise(found); t2 = cyc;
    chk(t1 - t0 == 21, "R2", "first period", t1 - t0, 21);
    chk(t2 - t1 == 21, "R2", "second period", t2 - t1, 21);
    wait_busy_low();
    enable = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk(seen == 0, "R2", "no refresh when disabled", seen, 0);
  endtask

  // R8: request during a burst waits for it to finish
  task automatic t_grant_midburst();
    bit found;
    int bad = 0;
    quiesce();
    interval = 16'd200; burst_len = 4'd1;
    wait_t1 = 3'd7; wait_t2 = 3'd7; wait_t3 = 3'd7;
    enable = 1'b1;
    wait_busy_rise(found);
    repeat (3) @(negedge clk);
    bus_req = 1'b1;
    while (busy) begin
      if (bus_grant) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8", "no grant during burst", bad, 0);
    chk(!bus_grant, "R8", "no grant in idle cycle", bus_grant, 0);
    @(negedge clk);
    chk(bus_grant && !busy, "R8", "grant after burst", bus_grant, 1);
    bus_req = 1'b0;
    @(negedge clk);
    chk(!bus_grant, "R8", "grant released", bus_grant, 0);
    enable = 1'b0;
  endtask

  // R9 R10: requests missed under grant are replayed (saturated)
  task automatic t_missed(input int periods, input int expect_bursts);
    bit found;
    int active = 0;
    int bursts = 0;
    logic prev_busy;
    quiesce();
    interval = 16'd63; burst_len = 4'd0;
    wait_t1 = 3'd0; wait_t2 = 3'd0; wait_t3 = 3'd0;
    enable = 1'b1;
    wait_busy_rise(found);
    wait_busy_low();
    bus_req = 1'b1;
    @(negedge clk);
    chk(bus_grant, "R8", "idle grant next cycle", bus_grant, 1);
    for (int i = 1; i < periods * 64; i++) begin
      if (!ref_frame_n || busy) active++;
      @(negedge clk);
    end
    chk(active == 0, "R9", "no refresh while granted", active, 0);
    bus_req = 1'b0;
    enable  = 1'b0;
    prev_busy = 1'b0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (busy && !prev_busy) bursts++;
      prev_busy = busy;
    end
    chk(bursts == expect_bursts, (periods > 7) ? "R10" : "R9",
        "replayed bursts", bursts, expect_bursts);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; bus_req = 1'b0;
    interval = '0; burst_len = '0; cs_sel = '0;
    wait_t1 = '0; wait_t2 = '0; wait_t3 = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shape();
    t_burst_count();
    t_interval();
    t_grant_midburst();
    t_missed(5, 5);
    t_missed(10, 7);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule